// File: doc/BRIEF.md
# Misspeculation Line Buffer

This block is a small, fully associative store of cache lines that sits next to an L1 data cache. Loads that were issued down a mispredicted branch or from a thread that has since been aborted carry a wrong-execution mark. Such loads may still go to memory as soon as their address is known. The lines they bring back are kept here rather than in L1, so they cannot evict useful L1 contents. If a later correct-path load misses L1 but finds its line here, it gets the data and the line is handed to L1 as a promotion.

The block has three request ports, each with a wrong-execution mark. The lookup port answers one cycle later with hit and line data. The fill port takes returning lines. Correct-path fills pass straight through to the L1 write port. Marked fills are kept here. The store port passes correct-path stores to memory and updates any copy held here. Marked stores are discarded. A lookup whose producer was flushed is dropped in the cycle it arrives.

Top module: `misspec_line_buffer`

## Requirements
- R1: After reset every entry is invalid, so the first lookup of any tag answers with rspHit low, and rspValid and promoteValid are low while no lookup is made.
- R2: A fill with fillWrong high is written only into this buffer and l1FillEn stays low. A fill with fillWrong low drives l1FillEn, l1FillTag and l1FillData in the same cycle and is not kept here.
- R3: A lookup that is not flushed produces rspValid exactly one cycle later. rspHit is high with rspData equal to the stored line when a valid entry holds the tag, and rspHit is low otherwise.
- R4: A lookup with lkWrong low that hits raises promoteValid in the response cycle, with promoteTag equal to the lookup tag and promoteData equal to the line. The entry is invalidated, so a later lookup of that tag misses.
- R5: A lookup with lkWrong high that hits returns the line, never raises promoteValid and leaves the entry in place.
- R6: A lookup presented with lkFlush high produces no response and no promotion, and it does not change the replacement order.
- R7: A store with stWrong high leaves memStoreEn low and leaves the buffered line unchanged. A store with stWrong low drives memStoreEn, memStoreTag and memStoreData, and it overwrites the line held here when its tag is present.
- R8: A marked fill whose tag is already held overwrites that entry, so a tag is never held twice.
- R9: A marked fill of a new tag goes to the lowest-numbered invalid entry while one exists, and no valid line is evicted.
- R10: When all 8 entries are valid, a marked fill of a new tag replaces the least recently used entry. Marked fills and marked lookup hits count as uses.
- R11: A lookup and a marked fill to the same tag in one cycle are answered with the fill data as a hit. If the lookup has lkWrong low, the line is promoted and not allocated. If the lookup is marked, the line is allocated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lkValid | input | 1 | Lookup request |
| lkWrong | input | 1 | Lookup comes from wrong execution |
| lkFlush | input | 1 | Lookup's producer was flushed this cycle; drop it |
| lkTag | input | TAG_W | Lookup line tag |
| fillValid | input | 1 | Returning line |
| fillWrong | input | 1 | Fill caused by a wrong-execution load |
| fillTag | input | TAG_W | Fill line tag |
| fillData | input | LINE_W | Fill line data |
| stValid | input | 1 | Store request |
| stWrong | input | 1 | Store comes from wrong execution |
| stTag | input | TAG_W | Store line tag |
| stData | input | LINE_W | Store line data |
| rspValid | output | 1 | Lookup response strobe |
| rspHit | output | 1 | Lookup found its line |
| rspData | output | LINE_W | Line returned by the lookup |
| promoteValid | output | 1 | Line to be installed in L1 |
| promoteTag | output | TAG_W | Tag of the promoted line |
| promoteData | output | LINE_W | Data of the promoted line |
| l1FillEn | output | 1 | Correct-path fill write to L1 |
| l1FillTag | output | TAG_W | Tag for the L1 fill |
| l1FillData | output | LINE_W | Data for the L1 fill |
| memStoreEn | output | 1 | Store allowed to update memory |
| memStoreTag | output | TAG_W | Tag of the forwarded store |
| memStoreData | output | LINE_W | Data of the forwarded store |

## Verification
The assertions check on every cycle that responses come exactly one cycle after unflushed lookups, that flushed and marked lookups never promote, that a promotion always comes with a hit, and that no tag ever matches two entries. Only the bench's scenarios can show which entry is replaced: lowest invalid slot first, then least recently used after every rotation of touch order. They also show that a flushed lookup leaves that order alone, that marked stores leave line contents untouched, and that same-cycle lookup and fill collisions resolve as required.

// File: rtl/wpb_pkg.sv
package wpb_pkg;
  parameter int unsigned ENTRIES = 8;
  localparam int unsigned IDX_W = $clog2(ENTRIES);

  typedef logic [IDX_W-1:0] idx_t;

  // Strobes from control to datapath, one set per cycle.
  typedef struct packed {
    logic alloc;
    idx_t allocIdx;
    logic inval;
    idx_t invalIdx;
    logic storeWr;
    idx_t storeIdx;
    logic rspEn;
    logic rspHit;
    logic rspFromFill;
    idx_t rspIdx;
    logic promote;
  } strobe_t;

  // Lowest set bit index (0 when none set).
  function automatic idx_t firstSet(input logic [ENTRIES-1:0] vec);
    idx_t idx;
    idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (vec[i]) idx = idx_t'(i);
    end
    return idx;
  endfunction
endpackage

// File: rtl/wpb_datapath.sv
module wpb_datapath
  import wpb_pkg::*;
#(
  parameter int unsigned TAG_W  = 16,
  parameter int unsigned LINE_W = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  strobe_t            st,
  input  logic [TAG_W-1:0]   lkTag,
  input  logic [TAG_W-1:0]   fillTag,
  input  logic [LINE_W-1:0]  fillData,
  input  logic [TAG_W-1:0]   stTag,
  input  logic [LINE_W-1:0]  stData,
  output logic [ENTRIES-1:0] lkHitVec,
  output logic [ENTRIES-1:0] fillHitVec,
  output logic [ENTRIES-1:0] stHitVec,
  output logic [ENTRIES-1:0] validVec,
  output logic               rspValid,
  output logic               rspHit,
  output logic [LINE_W-1:0]  rspData,
  output logic               promoteValid,
  output logic [TAG_W-1:0]   promoteTag,
  output logic [LINE_W-1:0]  promoteData
);
  logic [TAG_W-1:0]   tagQ  [ENTRIES];
  logic [LINE_W-1:0]  dataQ [ENTRIES];
  logic [ENTRIES-1:0] validQ;
  logic [LINE_W-1:0]  readLine;

  // Parallel tag compare, one comparator per entry and port.
  for (genvar g = 0; g < ENTRIES; g++) begin : g_match
    assign lkHitVec[g]   = validQ[g] && (tagQ[g] == lkTag);
    assign fillHitVec[g] = validQ[g] && (tagQ[g] == fillTag);
    assign stHitVec[g]   = validQ[g] && (tagQ[g] == stTag);
  end

  assign validVec = validQ;
  assign readLine = st.rspFromFill ? fillData : dataQ[st.rspIdx];

  // Line storage: a store is overridden by an allocation to the same slot.
  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (st.storeWr && st.storeIdx == idx_t'(i)) dataQ[i] <= stData;
      if (st.alloc && st.allocIdx == idx_t'(i)) begin
        dataQ[i] <= fillData;
        tagQ[i]  <= fillTag;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      validQ <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (st.inval && st.invalIdx == idx_t'(i)) validQ[i] <= 1'b0;
        if (st.alloc && st.allocIdx == idx_t'(i)) validQ[i] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rspValid     <= 1'b0;
      rspHit       <= 1'b0;
      rspData      <= '0;
      promoteValid <= 1'b0;
      promoteTag   <= '0;
      promoteData  <= '0;
    end else begin
      rspValid     <= st.rspEn;
      rspHit       <= st.rspEn && st.rspHit;
      rspData      <= readLine;
      promoteValid <= st.promote;
      promoteTag   <= lkTag;
      promoteData  <= readLine;
    end
  end
endmodule

// File: rtl/wpb_ctrl.sv
module wpb_ctrl
  import wpb_pkg::*;
#(
  parameter int unsigned TAG_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lkValid,
  input  logic               lkWrong,
  input  logic               lkFlush,
  input  logic [TAG_W-1:0]   lkTag,
  input  logic               fillValid,
  input  logic               fillWrong,
  input  logic [TAG_W-1:0]   fillTag,
  input  logic               stValid,
  input  logic               stWrong,
  input  logic [ENTRIES-1:0] lkHitVec,
  input  logic [ENTRIES-1:0] fillHitVec,
  input  logic [ENTRIES-1:0] stHitVec,
  input  logic [ENTRIES-1:0] validVec,
  output strobe_t            st
);
  localparam idx_t OLDEST = idx_t'(ENTRIES - 1);

  idx_t ageQ [ENTRIES];
  logic lkGo, fillGo, sameTag, lkHitAny, allocate, touch;
  idx_t lkIdx, lruIdx, victim, allocIdx, touchIdx;

  always_comb begin
    lkGo     = lkValid && !lkFlush;
    fillGo   = fillValid && fillWrong;
    sameTag  = lkGo && fillGo && (lkTag == fillTag);
    lkHitAny = |lkHitVec;
    lkIdx    = firstSet(lkHitVec);

    lruIdx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (ageQ[i] == OLDEST) lruIdx = idx_t'(i);
    end
    victim   = (&validVec) ? lruIdx : firstSet(~validVec);
    allocIdx = (|fillHitVec) ? firstSet(fillHitVec) : victim;
    allocate = fillGo && !(sameTag && !lkWrong);

    touch    = allocate || (lkGo && lkWrong && lkHitAny);
    touchIdx = allocate ? allocIdx : lkIdx;

    st             = '0;
    st.alloc       = allocate;
    st.allocIdx    = allocIdx;
    st.rspEn       = lkGo;
    st.rspHit      = lkHitAny || sameTag;
    st.rspFromFill = sameTag;
    st.rspIdx      = lkIdx;
    st.promote     = lkGo && !lkWrong && (lkHitAny || sameTag);
    st.inval       = lkGo && !lkWrong && lkHitAny;
    st.invalIdx    = lkIdx;
    st.storeWr     = stValid && !stWrong && (|stHitVec);
    st.storeIdx    = firstSet(stHitVec);
  end

  // Age ranks form a permutation; 0 is most recent, ENTRIES-1 is the victim.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) ageQ[i] <= idx_t'(i);
    end else if (touch) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (idx_t'(i) == touchIdx)         ageQ[i] <= '0;
        else if (ageQ[i] < ageQ[touchIdx]) ageQ[i] <= ageQ[i] + 1'b1;
      end
    end
  end
endmodule

// File: rtl/misspec_line_buffer.sv
module misspec_line_buffer
  import wpb_pkg::*;
#(
  parameter int unsigned TAG_W  = 16,
  parameter int unsigned LINE_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lkValid,
  input  logic              lkWrong,
  input  logic              lkFlush,
  input  logic [TAG_W-1:0]  lkTag,
  input  logic              fillValid,
  input  logic              fillWrong,
  input  logic [TAG_W-1:0]  fillTag,
  input  logic [LINE_W-1:0] fillData,
  input  logic              stValid,
  input  logic              stWrong,
  input  logic [TAG_W-1:0]  stTag,
  input  logic [LINE_W-1:0] stData,
  output logic              rspValid,
  output logic              rspHit,
  output logic [LINE_W-1:0] rspData,
  output logic              promoteValid,
  output logic [TAG_W-1:0]  promoteTag,
  output logic [LINE_W-1:0] promoteData,
  output logic              l1FillEn,
  output logic [TAG_W-1:0]  l1FillTag,
  output logic [LINE_W-1:0] l1FillData,
  output logic              memStoreEn,
  output logic [TAG_W-1:0]  memStoreTag,
  output logic [LINE_W-1:0] memStoreData
);
  strobe_t            strobe;
  logic [ENTRIES-1:0] lkHitVec, fillHitVec, stHitVec, validVec;

  // Correct-path traffic passes through; marked traffic stays here or is dropped.
  assign l1FillEn     = fillValid && !fillWrong;
  assign l1FillTag    = fillTag;
  assign l1FillData   = fillData;
  assign memStoreEn   = stValid && !stWrong;
  assign memStoreTag  = stTag;
  assign memStoreData = stData;

  wpb_ctrl #(.TAG_W(TAG_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .lkValid(lkValid), .lkWrong(lkWrong), .lkFlush(lkFlush), .lkTag(lkTag),
    .fillValid(fillValid), .fillWrong(fillWrong), .fillTag(fillTag),
    .stValid(stValid), .stWrong(stWrong),
    .lkHitVec(lkHitVec), .fillHitVec(fillHitVec), .stHitVec(stHitVec),
    .validVec(validVec), .st(strobe)
  );

  wpb_datapath #(.TAG_W(TAG_W), .LINE_W(LINE_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .st(strobe),
    .lkTag(lkTag), .fillTag(fillTag), .fillData(fillData),
    .stTag(stTag), .stData(stData),
    .lkHitVec(lkHitVec), .fillHitVec(fillHitVec), .stHitVec(stHitVec),
    .validVec(validVec),
    .rspValid(rspValid), .rspHit(rspHit), .rspData(rspData),
    .promoteValid(promoteValid), .promoteTag(promoteTag), .promoteData(promoteData)
  );
endmodule

// File: rtl/misspec_line_buffer_chk.sv
module misspec_line_buffer_chk #(
  parameter int unsigned ENTRIES = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               lkValid,
  input logic               lkWrong,
  input logic               lkFlush,
  input logic               rspValid,
  input logic               rspHit,
  input logic               promoteValid,
  input logic [ENTRIES-1:0] lkHitVec,
  input logic [ENTRIES-1:0] fillHitVec
);
  p_rsp_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rspValid == $past(lkValid && !lkFlush));

  p_hit_has_rsp_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rspHit |-> rspValid);

  p_flush_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lkValid && lkFlush) |=> (!rspValid && !promoteValid));

  p_promote_on_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    promoteValid |-> (rspValid && rspHit));

  p_marked_no_promote_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (lkValid && lkWrong) |=> !promoteValid);

  p_unique_lookup_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lkHitVec));

  p_unique_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fillHitVec));
endmodule

bind misspec_line_buffer misspec_line_buffer_chk #(.ENTRIES(wpb_pkg::ENTRIES)) u_chk (
  .clk(clk), .rst_n(rst_n), .lkValid(lkValid), .lkWrong(lkWrong), .lkFlush(lkFlush),
  .rspValid(rspValid), .rspHit(rspHit), .promoteValid(promoteValid),
  .lkHitVec(lkHitVec), .fillHitVec(fillHitVec)
);

// File: tb/misspec_line_buffer_tb.sv
module misspec_line_buffer_tb;
  localparam int TW = 8;
  localparam int LW = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic lkValid = 0, lkWrong = 0, lkFlush = 0, fillValid = 0, fillWrong = 0;
  logic stValid = 0, stWrong = 0;
  logic [TW-1:0] lkTag = '0, fillTag = '0, stTag = '0;
  logic [LW-1:0] fillData = '0, stData = '0;
  logic rspValid, rspHit, promoteValid, l1FillEn, memStoreEn;
  logic [LW-1:0] rspData, promoteData, l1FillData, memStoreData;
  logic [TW-1:0] promoteTag, l1FillTag, memStoreTag;

  int checks = 0, errors = 0;
  logic [TW-1:0] slots [8];

  always #10 clk = ~clk;

  misspec_line_buffer #(.TAG_W(TW), .LINE_W(LW)) u_dut (.*);

  function automatic logic [LW-1:0] lineOf(input logic [TW-1:0] t, input logic [7:0] salt);
    return {t, ~t, t ^ salt, salt};
  endfunction

  task automatic chk(input string req, input string what, input logic [LW-1:0] act, input logic [LW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  // Drive at a falling edge; response is registered, sample at the next falling edge.
  task automatic lookup(input logic [TW-1:0] t, input bit wrong, input bit flush,
                        output bit v, output bit h, output logic [LW-1:0] d,
                        output bit pv, output logic [TW-1:0] pt, output logic [LW-1:0] pd);
    lkValid = 1; lkTag = t; lkWrong = wrong; lkFlush = flush;
    @(negedge clk);
    lkValid = 0; lkFlush = 0;
    v = rspValid; h = rspHit; d = rspData; pv = promoteValid; pt = promoteTag; pd = promoteData;
  endtask

  task automatic fill(input logic [TW-1:0] t, input logic [LW-1:0] d, input bit wrong,
                      output bit l1en, output logic [TW-1:0] l1t, output logic [LW-1:0] l1d);
    fillValid = 1; fillTag = t; fillData = d; fillWrong = wrong;
    #1; l1en = l1FillEn; l1t = l1FillTag; l1d = l1FillData;
    @(negedge clk);
    fillValid = 0;
  endtask

  task automatic store(input logic [TW-1:0] t, input logic [LW-1:0] d, input bit wrong,
                       output bit en, output logic [TW-1:0] mt, output logic [LW-1:0] md);
    stValid = 1; stTag = t; stData = d; stWrong = wrong;
    #1; en = memStoreEn; mt = memStoreTag; md = memStoreData;
    @(negedge clk);
    stValid = 0;
  endtask

  task automatic both(input logic [TW-1:0] t, input logic [LW-1:0] d, input bit lkW,
                      output bit h, output logic [LW-1:0] rd, output bit pv, output logic [LW-1:0] pd);
    lkValid = 1; lkTag = t; lkWrong = lkW; lkFlush = 0;
    fillValid = 1; fillTag = t; fillData = d; fillWrong = 1;
    @(negedge clk);
    lkValid = 0; fillValid = 0;
    h = rspHit; rd = rspData; pv = promoteValid; pd = promoteData;
  endtask

  initial begin
    #(20 * 20000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit v, h, pv, en;
    logic [LW-1:0] d, pd;
    logic [TW-1:0] pt;

    doReset();
    @(negedge clk);
    // R1: idle outputs and empty buffer
    chk("R1", "rspValid idle", LW'(rspValid), 0);
    chk("R1", "promoteValid idle", LW'(promoteValid), 0);
    lookup(8'h11, 1, 0, v, h, d, pv, pt, pd);
    chk("R1", "rspValid", LW'(v), 1);
    chk("R1", "miss after reset", LW'(h), 0);

    // R2: correct fill goes to L1 only
    fill(8'h20, lineOf(8'h20, 1), 0, en, pt, d);
    chk("R2", "l1FillEn correct", LW'(en), 1);
    chk("R2", "l1FillTag", LW'(pt), LW'(8'h20));
    chk("R2", "l1FillData", d, lineOf(8'h20, 1));
    lookup(8'h20, 1, 0, v, h, d, pv, pt, pd);
    chk("R2", "correct fill not buffered", LW'(h), 0);
    fill(8'h21, lineOf(8'h21, 2), 1, en, pt, d);
    chk("R2", "l1FillEn marked", LW'(en), 0);
    // R3 / R5: marked lookup hit, no promotion, entry kept
    lookup(8'h21, 1, 0, v, h, d, pv, pt, pd);
    chk("R3", "hit", LW'(h), 1);
    chk("R3", "data", d, lineOf(8'h21, 2));
    chk("R5", "no promote", LW'(pv), 0);
    lookup(8'h21, 1, 0, v, h, d, pv, pt, pd);
    chk("R5", "entry kept", LW'(h), 1);

    // R4: correct lookup promotes and invalidates
    lookup(8'h21, 0, 0, v, h, d, pv, pt, pd);
    chk("R4", "promoteValid", LW'(pv), 1);
    chk("R4", "promoteTag", LW'(pt), LW'(8'h21));
    chk("R4", "promoteData", pd, lineOf(8'h21, 2));
    lookup(8'h21, 1, 0, v, h, d, pv, pt, pd);
    chk("R4", "invalidated", LW'(h), 0);

    // R6: flushed lookup is silent
    fill(8'h22, lineOf(8'h22, 3), 1, en, pt, d);
    lookup(8'h22, 0, 1, v, h, d, pv, pt, pd);
    chk("R6", "no rsp on flush", LW'(v), 0);
    chk("R6", "no promote on flush", LW'(pv), 0);
    lookup(8'h22, 1, 0, v, h, d, pv, pt, pd);
    chk("R6", "entry survives flush", LW'(h), 1);

    // R7: stores
    fill(8'h30, lineOf(8'h30, 4), 1, en, pt, d);
    store(8'h30, 32'hdead0001, 1, en, pt, d);
    chk("R7", "marked store blocked", LW'(en), 0);
    lookup(8'h30, 1, 0, v, h, d, pv, pt, pd);
    chk("R7", "line unchanged", d, lineOf(8'h30, 4));
    store(8'h30, 32'hbeef0002, 0, en, pt, d);
    chk("R7", "correct store passes", LW'(en), 1);
    chk("R7", "memStoreData", d, 32'hbeef0002);
    lookup(8'h30, 1, 0, v, h, d, pv, pt, pd);
    chk("R7", "line updated", d, 32'hbeef0002);

    // R8: refill of same tag overwrites, no duplicate
    fill(8'h40, lineOf(8'h40, 5), 1, en, pt, d);
    fill(8'h40, lineOf(8'h40, 6), 1, en, pt, d);
    lookup(8'h40, 0, 0, v, h, d, pv, pt, pd);
    chk("R8", "latest data promoted", pd, lineOf(8'h40, 6));
    lookup(8'h40, 1, 0, v, h, d, pv, pt, pd);
    chk("R8", "no duplicate left", LW'(h), 0);

    // R11: same-cycle lookup and fill
    both(8'h50, lineOf(8'h50, 7), 1, h, d, pv, pd);
    chk("R11", "marked hit", LW'(h), 1);
    chk("R11", "fill data forwarded", d, lineOf(8'h50, 7));
    lookup(8'h50, 1, 0, v, h, d, pv, pt, pd);
    chk("R11", "marked collision allocates", LW'(h), 1);
    both(8'h51, lineOf(8'h51, 8), 0, h, d, pv, pd);
    chk("R11", "correct collision promotes", LW'(pv), 1);
    chk("R11", "promote fill data", pd, lineOf(8'h51, 8));
    lookup(8'h51, 1, 0, v, h, d, pv, pt, pd);
    chk("R11", "correct collision not allocated", LW'(h), 0);

    // R9: invalid slots are used first
    doReset();
    for (int i = 0; i < 8; i++) begin
      slots[i] = 8'h80 + 8'(i);
      fill(slots[i], lineOf(slots[i], 9), 1, en, pt, d);
    end
    lookup(8'h83, 0, 0, v, h, d, pv, pt, pd);
    slots[3] = 8'h90;
    fill(8'h90, lineOf(8'h90, 9), 1, en, pt, d);
    for (int i = 0; i < 8; i++) begin
      lookup(slots[i], 1, 0, v, h, d, pv, pt, pd);
      chk("R9", "all lines resident", LW'(h), 1);
    end

    // R10 (with R6): rotate touch order, evict the least recently used
    for (int r = 0; r < 8; r++) begin
      logic [TW-1:0] nt;
      for (int j = 0; j < 8; j++) lookup(slots[(r + j) % 8], 1, 0, v, h, d, pv, pt, pd);
      lookup(slots[r], 1, 1, v, h, d, pv, pt, pd);
      nt = 8'hA0 + 8'(r);
      fill(nt, lineOf(nt, 10), 1, en, pt, d);
      lookup(slots[r], 1, 0, v, h, d, pv, pt, pd);
      chk("R10", "LRU evicted", LW'(h), 0);
      lookup(nt, 1, 0, v, h, d, pv, pt, pd);
      chk("R10", "new line present", d, lineOf(nt, 10));
      lookup(slots[(r + 1) % 8], 1, 0, v, h, d, pv, pt, pd);
      chk("R10", "neighbour kept", LW'(h), 1);
      slots[r] = nt;
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule